// File: doc/BRIEF.md
# USB PHY Retention and Wake-Arm Sequencer

This block runs the short register programs that put a high-speed USB PHY into its low-power retention state and bring it back out. It is a master on a byte-wide request/acknowledge register port. A power-down request sets the PHY's analog power-down bit and flushes stale line-state events. It then arms the DP/DM edge detectors that should wake the system. Which edges it arms depends on the link mode sampled when the request is taken. A power-up request disarms those detectors, flushes pending events again, and only then releases the analog power-down bit.

Each program is a fixed list of seven steps. The steps are read-modify-write cycles, plain writes, and two timed settle waits around a pulse of the PHY's interrupt command register. The waits are counted in microseconds. A prescaler derives the microsecond tick from a clock-cycles-per-microsecond parameter. While a program runs, `busy` is high and new requests are dropped. A single-cycle `done` marks the end of the program.

Top module: `usb_phy_wake_seq`

## Requirements
- R1: After reset, `busy`, `done` and `bus_req` are low, and no bus cycle is issued while idle.
- R2: A power-down program writes, in this order: control register 0x78, clear register 0xdc, command register 0xd0 with 0x00, then 0xd0 with 0x01, then mask register 0xd4. A power-up program writes 0xd4, 0xdc, 0xd0 with 0x00, 0xd0 with 0x01, and finally 0x78. Each program takes 8 bus cycles: three read-modify-writes of two cycles each, plus two plain writes.
- R3: Power-down sets bit 2 (value 0x04) of register 0x78, and it does so as the first step. Power-up clears that bit as the last step.
- R4: Both programs OR the line-event field 0x1e into register 0xdc. They then write 0x00 and then 0x01 to register 0xd0.
- R5: At least WAIT_US × CYC_PER_US clock cycles pass between the command write of 0x00 and the write of 0x01. At least as many pass again after the write of 0x01 before the next bus cycle.
- R6: Power-down ORs a wake pattern into register 0xd4. The pattern is chosen by `link_mode`, encoded as 0 none, 1 host high speed, 2 host full speed, 3 host low speed, 4 device high speed, 5 device full speed, 6 device low speed, 7 unused. Modes 1, 2, 4 and 5 give 0x12 (DP falling, bit 4, plus DM rising, bit 1). Modes 3 and 6 give 0x0c (DP rising, bit 3, plus DM falling, bit 2). Modes 0 and 7 give 0x0a (DP rising plus DM rising).
- R7: Power-up clears the bits of field 0x1e in register 0xd4.
- R8: Every read-modify-write leaves the bits outside its target field as they were read.
- R9: A request that arrives while `busy` is high has no effect. `busy` stays high through the cycle in which `done` pulses, and `done` is high for exactly one cycle per program.
- R10: If power-down and power-up are requested in the same idle cycle, the power-down program runs.
- R11: Once `bus_req` is raised, it stays high with `bus_we`, `bus_addr` and `bus_wdata` unchanged until the cycle in which `bus_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_off_req | input | 1 | Start the power-down (retention entry) program |
| pwr_on_req | input | 1 | Start the power-up (retention exit) program |
| link_mode | input | 3 | Attached role and speed, sampled when a request is accepted |
| busy | output | 1 | A program is running |
| done | output | 1 | One-cycle pulse at the end of a program |
| bus_req | output | 1 | Register bus cycle request |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | 8 | Register byte offset |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with bus_ack on a read |
| bus_ack | input | 1 | Completes the current bus cycle |

## Verification
The bench preloads the PHY register model with bytes whose bits lie both inside and outside the targeted fields. A read-modify-write that wrote a constant, or used the wrong AND/OR sense, would then leave a wrong final byte. Every link-mode code is driven, including the unused code 7. A decoder that swapped the low-speed and full-speed patterns, or left code 7 unarmed, therefore shows up in the mask register. The gaps between the command writes are measured against the parameterised wait, which catches a prescaler that ends early. Requests raised mid-program and simultaneous power-up/power-down requests expose a sequencer that restarts or lets the wrong program win.

// File: rtl/usb_wake_pkg.sv
package usb_wake_pkg;

    localparam logic [7:0] REG_CTRL  = 8'h78;
    localparam logic [7:0] REG_CMD   = 8'hd0;
    localparam logic [7:0] REG_MASK  = 8'hd4;
    localparam logic [7:0] REG_CLEAR = 8'hdc;

    localparam logic [7:0] RETAIN_BIT = 8'h04;
    localparam logic [7:0] LINE_FIELD = 8'h1e;
    localparam logic [7:0] DP_FALL    = 8'h10;
    localparam logic [7:0] DP_RISE    = 8'h08;
    localparam logic [7:0] DM_FALL    = 8'h04;
    localparam logic [7:0] DM_RISE    = 8'h02;

    localparam int STEP_COUNT = 7;
    localparam int STEP_W     = $clog2(STEP_COUNT);

    typedef enum logic [1:0] {
        OP_SET  = 2'd0,
        OP_CLR  = 2'd1,
        OP_PUT  = 2'd2,
        OP_WAIT = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic [7:0] addr;
        logic [7:0] data;
    } bus_op_t;

    typedef enum logic [2:0] {
        LM_NONE    = 3'd0,
        LM_HOST_HS = 3'd1,
        LM_HOST_FS = 3'd2,
        LM_HOST_LS = 3'd3,
        LM_DEV_HS  = 3'd4,
        LM_DEV_FS  = 3'd5,
        LM_DEV_LS  = 3'd6,
        LM_UNUSED  = 3'd7
    } link_mode_e;

    // Wake edges to arm for a given attached speed; unknown codes count as detached.
    function automatic logic [7:0] wake_edges(input logic [2:0] mode);
        logic [7:0] r;
        case (link_mode_e'(mode))
            LM_HOST_HS, LM_HOST_FS, LM_DEV_HS, LM_DEV_FS: r = DP_FALL | DM_RISE;
            LM_HOST_LS, LM_DEV_LS:                        r = DP_RISE | DM_FALL;
            default:                                      r = DP_RISE | DM_RISE;
        endcase
        return r;
    endfunction

    // Step table of both programs. going_down selects retention entry.
    function automatic bus_op_t step_op(input logic going_down,
                                        input logic [STEP_W-1:0] idx,
                                        input logic [7:0] edges);
        bus_op_t o;
        o = '{kind: OP_WAIT, addr: 8'h00, data: 8'h00};
        case (idx)
            STEP_W'(0): o = going_down ? '{OP_SET, REG_CTRL, RETAIN_BIT}
                                      : '{OP_CLR, REG_MASK, LINE_FIELD};
            STEP_W'(1): o = '{OP_SET, REG_CLEAR, LINE_FIELD};
            STEP_W'(2): o = '{OP_PUT, REG_CMD, 8'h00};
            STEP_W'(3): o = '{OP_WAIT, 8'h00, 8'h00};
            STEP_W'(4): o = '{OP_PUT, REG_CMD, 8'h01};
            STEP_W'(5): o = '{OP_WAIT, 8'h00, 8'h00};
            default:    o = going_down ? '{OP_SET, REG_MASK, edges}
                                      : '{OP_CLR, REG_CTRL, RETAIN_BIT};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/usb_wake_timer.sv
module usb_wake_timer #(
    parameter int CYC_PER_US = 125,
    parameter int WAIT_US    = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expire
);
    localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam int UW = (WAIT_US > 1) ? $clog2(WAIT_US) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_US - 1);
    localparam logic [UW-1:0] US_LAST  = UW'(WAIT_US - 1);

    logic          running;
    logic [PW-1:0] pre_cnt;
    logic [UW-1:0] us_cnt;
    logic          tick;

    assign tick   = running && (pre_cnt == PRE_LAST);
    assign expire = tick && (us_cnt == US_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            pre_cnt <= '0;
            us_cnt  <= '0;
        end else if (start) begin
            running <= 1'b1;
            pre_cnt <= '0;
            us_cnt  <= '0;
        end else if (running) begin
            if (tick) begin
                pre_cnt <= '0;
                if (expire) running <= 1'b0;
                else        us_cnt  <= us_cnt + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/usb_wake_bus.sv
module usb_wake_bus
    import usb_wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  bus_op_t    op,
    output logic       finished,
    output logic       bus_req,
    output logic       bus_we,
    output logic [7:0] bus_addr,
    output logic [7:0] bus_wdata,
    input  logic [7:0] bus_rdata,
    input  logic       bus_ack
);
    typedef enum logic [1:0] {B_IDLE, B_READ, B_WRITE} bstate_e;

    bstate_e    state;
    op_kind_e   kind_q;
    logic [7:0] arg_q;

    assign bus_req  = (state != B_IDLE);
    assign bus_we   = (state == B_WRITE);
    assign finished = (state == B_WRITE) && bus_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= B_IDLE;
            kind_q    <= OP_PUT;
            arg_q     <= '0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else begin
            case (state)
                B_IDLE: if (start) begin
                    kind_q    <= op.kind;
                    arg_q     <= op.data;
                    bus_addr  <= op.addr;
                    bus_wdata <= op.data;
                    state     <= (op.kind == OP_PUT) ? B_WRITE : B_READ;
                end
                B_READ: if (bus_ack) begin
                    bus_wdata <= (kind_q == OP_SET) ? (bus_rdata | arg_q)
                                                    : (bus_rdata & ~arg_q);
                    state     <= B_WRITE;
                end
                B_WRITE: if (bus_ack) state <= B_IDLE;
                default: state <= B_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usb_wake_ctrl.sv
module usb_wake_ctrl
    import usb_wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       off_req,
    input  logic       on_req,
    input  logic [2:0] link_mode,
    input  logic       bus_fin,
    input  logic       tmr_exp,
    output logic       bus_start,
    output bus_op_t    bus_op,
    output logic       tmr_start,
    output logic       busy,
    output logic       done
);
    typedef enum logic [2:0] {C_IDLE, C_ISSUE, C_BUS, C_TIMER, C_DONE} cstate_e;

    cstate_e           state;
    logic              going_down;
    logic [7:0]        edges_q;
    logic [STEP_W-1:0] idx;
    logic              step_end;

    assign bus_op    = step_op(going_down, idx, edges_q);
    assign bus_start = (state == C_ISSUE) && (bus_op.kind != OP_WAIT);
    assign tmr_start = (state == C_ISSUE) && (bus_op.kind == OP_WAIT);
    assign step_end  = ((state == C_BUS) && bus_fin) || ((state == C_TIMER) && tmr_exp);
    assign busy      = (state != C_IDLE);
    assign done      = (state == C_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= C_IDLE;
            going_down <= 1'b0;
            edges_q    <= '0;
            idx        <= '0;
        end else begin
            case (state)
                C_IDLE: if (off_req || on_req) begin
                    going_down <= off_req;
                    edges_q    <= wake_edges(link_mode);
                    idx        <= '0;
                    state      <= C_ISSUE;
                end
                C_ISSUE: state <= tmr_start ? C_TIMER : C_BUS;
                C_BUS, C_TIMER: if (step_end) begin
                    if (idx == STEP_W'(STEP_COUNT - 1)) begin
                        state <= C_DONE;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= C_ISSUE;
                    end
                end
                C_DONE:  state <= C_IDLE;
                default: state <= C_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usb_phy_wake_seq.sv
module usb_phy_wake_seq
    import usb_wake_pkg::*;
#(
    parameter int CYC_PER_US = 125,
    parameter int WAIT_US    = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_off_req,
    input  logic       pwr_on_req,
    input  logic [2:0] link_mode,
    output logic       busy,
    output logic       done,
    output logic       bus_req,
    output logic       bus_we,
    output logic [7:0] bus_addr,
    output logic [7:0] bus_wdata,
    input  logic [7:0] bus_rdata,
    input  logic       bus_ack
);
    logic    bus_start;
    logic    bus_fin;
    logic    tmr_start;
    logic    tmr_exp;
    bus_op_t cur_op;

    usb_wake_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .off_req   (pwr_off_req),
        .on_req    (pwr_on_req),
        .link_mode (link_mode),
        .bus_fin   (bus_fin),
        .tmr_exp   (tmr_exp),
        .bus_start (bus_start),
        .bus_op    (cur_op),
        .tmr_start (tmr_start),
        .busy      (busy),
        .done      (done)
    );

    usb_wake_bus u_bus (
        .clk       (clk),
        .rst       (rst),
        .start     (bus_start),
        .op        (cur_op),
        .finished  (bus_fin),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack)
    );

    usb_wake_timer #(
        .CYC_PER_US (CYC_PER_US),
        .WAIT_US    (WAIT_US)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (tmr_start),
        .expire (tmr_exp)
    );
endmodule

// File: rtl/usb_phy_wake_seq_chk.sv
module usb_phy_wake_seq_chk #(
    parameter int CYC_PER_US = 125,
    parameter int WAIT_US    = 200
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       bus_req,
    input logic       bus_we,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_ack
);
    localparam int GAP_MIN = CYC_PER_US * WAIT_US;

    int  gap_cnt;
    logic cmd_low_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt      <= 0;
            cmd_low_seen <= 1'b0;
        end else if (bus_req && bus_we && bus_ack && bus_addr == 8'hd0 && bus_wdata == 8'h00) begin
            gap_cnt      <= 0;
            cmd_low_seen <= 1'b1;
        end else if (gap_cnt < GAP_MIN + 4) begin
            gap_cnt <= gap_cnt + 1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req);

    assert_hold_fields_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    assert_busy_end_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    assert_cmd_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_addr == 8'hd0 && bus_wdata == 8'h01 && cmd_low_seen) |-> (gap_cnt >= GAP_MIN));
endmodule

bind usb_phy_wake_seq usb_phy_wake_seq_chk #(
    .CYC_PER_US (CYC_PER_US),
    .WAIT_US    (WAIT_US)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack)
);

// File: tb/usb_phy_wake_seq_test.sv
module usb_phy_wake_seq_test;
    localparam int CYC = 4;
    localparam int WUS = 5;
    localparam int WAIT_CYC = CYC * WUS;

    typedef struct packed {
        logic       off;
        logic [2:0] mode;
        logic [7:0] i78, id4, idc, e78, ed4, edc;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd1, 8'h08, 8'h00, 8'h00, 8'h0c, 8'h12, 8'h1e},
        '{1'b1, 3'd2, 8'hf3, 8'he1, 8'h41, 8'hf7, 8'hf3, 8'h5f},
        '{1'b1, 3'd3, 8'h00, 8'h00, 8'h80, 8'h04, 8'h0c, 8'h9e},
        '{1'b1, 3'd4, 8'h04, 8'h21, 8'h00, 8'h04, 8'h33, 8'h1e},
        '{1'b1, 3'd6, 8'h10, 8'h40, 8'h00, 8'h14, 8'h4c, 8'h1e},
        '{1'b1, 3'd0, 8'h01, 8'h00, 8'h01, 8'h05, 8'h0a, 8'h1f},
        '{1'b1, 3'd7, 8'h00, 8'h80, 8'h00, 8'h04, 8'h8a, 8'h1e},
        '{1'b0, 3'd1, 8'hff, 8'hff, 8'h00, 8'hfb, 8'he1, 8'h1e},
        '{1'b0, 3'd3, 8'h04, 8'h1e, 8'h20, 8'h00, 8'h00, 8'h3e},
        '{1'b1, 3'd5, 8'h00, 8'h00, 8'h00, 8'h04, 8'h12, 8'h1e}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_off_req = 1'b0;
    logic       pwr_on_req = 1'b0;
    logic [2:0] link_mode = 3'd0;
    logic       busy, done, bus_req, bus_we;
    logic [7:0] bus_addr, bus_wdata;
    logic [7:0] bus_rdata = 8'h00;
    logic       bus_ack = 1'b0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // register model and log, all owned by the slave process
    logic [7:0] mem [256];
    logic       pre_en = 1'b0;
    logic [7:0] pre_addr = 8'h00, pre_data = 8'h00;
    logic       log_clr = 1'b0;
    int         n_tx, n_wr, done_hi, hold_err;
    logic [7:0] wr_addr [16];
    logic [7:0] wr_data [16];
    int         wr_cyc  [16];
    logic       prev_wait;
    logic [7:0] prev_addr, prev_wdata;
    logic       prev_we;

    usb_phy_wake_seq #(.CYC_PER_US(CYC), .WAIT_US(WUS)) uut (
        .clk(clk), .rst(rst), .pwr_off_req(pwr_off_req), .pwr_on_req(pwr_on_req),
        .link_mode(link_mode), .busy(busy), .done(done), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (pre_en) mem[pre_addr] <= pre_data;
        if (log_clr) begin
            n_tx <= 0; n_wr <= 0; done_hi <= 0;
        end
        if (rst) begin
            bus_ack <= 1'b0; hold_err <= 0; prev_wait <= 1'b0;
        end else begin
            if (done && !log_clr) done_hi <= done_hi + 1;
            if (prev_wait && (!bus_req || bus_addr != prev_addr || bus_we != prev_we || bus_wdata != prev_wdata))
                hold_err <= hold_err + 1;
            prev_wait  <= bus_req && !bus_ack;
            prev_addr  <= bus_addr; prev_we <= bus_we; prev_wdata <= bus_wdata;
            if (bus_req && !bus_ack) begin
                bus_ack <= 1'b1;
                if (!log_clr) n_tx <= n_tx + 1;
                if (bus_we) begin
                    mem[bus_addr] <= bus_wdata;
                    if (!log_clr && n_wr < 16) begin
                        wr_addr[n_wr] <= bus_addr;
                        wr_data[n_wr] <= bus_wdata;
                        wr_cyc[n_wr]  <= cyc;
                        n_wr <= n_wr + 1;
                    end
                end else begin
                    bus_rdata <= mem[bus_addr];
                end
            end else begin
                bus_ack <= 1'b0;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        pre_en = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    task automatic preload(input vec_t v);
        poke(8'h78, v.i78);
        poke(8'hd4, v.id4);
        poke(8'hdc, v.idc);
        poke(8'hd0, 8'h55);
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 2000) check("R9", "timeout waiting for done", 0, 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse(input logic off, input logic on, input logic [2:0] m);
        @(negedge clk);
        pwr_off_req = off; pwr_on_req = on; link_mode = m;
        @(negedge clk);
        pwr_off_req = 1'b0; pwr_on_req = 1'b0; link_mode = 3'd2;
    endtask

    task automatic check_result(input vec_t v, input string tag);
        logic [7:0] ea [5];
        logic [7:0] ed [5];
        int bad;
        if (v.off) begin
            ea = '{8'h78, 8'hdc, 8'hd0, 8'hd0, 8'hd4};
            ed = '{v.e78, v.edc, 8'h00, 8'h01, v.ed4};
        end else begin
            ea = '{8'hd4, 8'hdc, 8'hd0, 8'hd0, 8'h78};
            ed = '{v.ed4, v.edc, 8'h00, 8'h01, v.e78};
        end
        check("R3", {tag, " ctrl reg 0x78 (R8 other bits)"}, mem[8'h78], v.e78);
        check(v.off ? "R6" : "R7", {tag, " mask reg 0xd4 (R8 other bits)"}, mem[8'hd4], v.ed4);
        check("R4", {tag, " clear reg 0xdc"}, mem[8'hdc], v.edc);
        check("R4", {tag, " command reg final"}, mem[8'hd0], 8'h01);
        check("R2", {tag, " bus cycle count"}, n_tx, 8);
        check("R2", {tag, " write count"}, n_wr, 5);
        bad = 0;
        for (int i = 0; i < 5; i++)
            if (wr_addr[i] != ea[i] || wr_data[i] != ed[i]) bad++;
        check("R2", {tag, " write order mismatches"}, bad, 0);
        check("R5", {tag, " gap cmd 0 to cmd 1 >= wait"}, int'(wr_cyc[3] - wr_cyc[2] >= WAIT_CYC), 1);
        check("R5", {tag, " gap after cmd 1 >= wait"}, int'(wr_cyc[4] - wr_cyc[3] >= WAIT_CYC), 1);
        check("R9", {tag, " done high cycles"}, done_hi, 1);
    endtask

    initial begin
        #1600000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "busy after reset", busy, 0);
        check("R1", "done after reset", done, 0);
        check("R1", "bus_req after reset", bus_req, 0);
        repeat (10) @(negedge clk);
        check("R1", "no bus cycle while idle", int'(bus_ack | bus_req), 0);

        for (int k = 0; k < NV; k++) begin
            preload(VEC[k]);
            pulse(VEC[k].off, !VEC[k].off, VEC[k].mode);
            check("R9", "busy right after request", busy, 1);
            wait_done();
            check_result(VEC[k], $sformatf("vec%0d", k));
        end

        // R9: requests during a running program are dropped
        begin
            vec_t v;
            v = '{1'b1, 3'd1, 8'h00, 8'h00, 8'h00, 8'h04, 8'h12, 8'h1e};
            preload(v);
            pulse(1'b1, 1'b0, 3'd1);
            repeat (15) @(negedge clk);
            pulse(1'b0, 1'b1, 3'd3);
            repeat (10) @(negedge clk);
            pulse(1'b1, 1'b0, 3'd3);
            wait_done();
            check_result(v, "R9 ignore-while-busy");
            check("R9", "busy low after done", busy, 0);
        end

        // R10: simultaneous requests pick power-down
        begin
            vec_t v;
            v = '{1'b1, 3'd3, 8'h20, 8'h00, 8'h00, 8'h24, 8'h0c, 8'h1e};
            preload(v);
            pulse(1'b1, 1'b1, 3'd3);
            wait_done();
            check_result(v, "R10 both requests");
        end

        check("R11", "bus fields held until ack", hold_err, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule